// File: doc/BRIEF.md
# Hamming 7-4 Single-Error-Correcting Codec

This block packs an encoder and a decoder for a seven-bit, single-error-correcting code that protects four data bits. The encoder takes a four-bit word and returns a seven-bit codeword. The three even-parity bits lead the codeword and the data follows unchanged. The decoder takes a received seven-bit word and forms a three-bit syndrome from a fixed check matrix. If the syndrome is nonzero, the decoder inverts the one position whose check column equals it. It then drops the parity positions to recover the data, and reports both the syndrome and an error flag.

The two paths are independent. Each has its own input strobe, and each has an output register with a matching valid bit one clock later. A caller can therefore protect a word on its way out and repair another on its way in during the same cycle. A double flip is not detected; it is miscorrected without warning.

Bit convention used throughout: a codeword vector is written position 1 first. Position 1 is bit 6 and position 7 is bit 0. A data vector is written d1 first, with d1 in bit 3 and d4 in bit 0. A syndrome is written check row 1 first, with row 1 in bit 2.

Top module: `sec74_codec`

## Requirements
- R1: The codeword carries, in positions 1 to 7, the bits p1, p2, p3, d1, d2, d3, d4. The parity bits are even: p1 = d2^d3^d4, p2 = d1^d3^d4 and p3 = d1^d2^d4. Data 1010 gives codeword 1011010.
- R2: A word presented with `encValid` high appears on `encCode` after the next rising clock edge, with `encOutValid` high for exactly that one cycle. In any cycle that follows a clock edge with `encValid` low, `encOutValid` is low.
- R3: The syndrome is the modulo-2 product of the check rows and the received word. Row 1 is 1000111, row 2 is 0101011 and row 3 is 0011101, each written over positions 1 to 7. Received word 1011011 gives syndrome 111.
- R4: When the syndrome is 000, the received word is taken unchanged and `decError` is 0.
- R5: A nonzero syndrome inverts exactly one position, and `decError` is 1. The mapping is 100 to position 1, 010 to 2, 001 to 3, 011 to 4, 101 to 5, 110 to 6 and 111 to 7. Any single flipped position of a valid codeword is therefore repaired.
- R6: `decData` is positions 4 to 7 of the corrected word. Received word 1011011 decodes to data 1010.
- R7: A word presented with `decValid` high yields `decData`, `decSyndrome` and `decError` after the next rising edge, with `decOutValid` high for that one cycle.
- R8: A synchronous active-high `rst` clears all codeword, data, syndrome, flag and valid outputs to zero at the next edge, including mid-run.
- R9: While a path's input strobe is low, that path's data outputs keep their last values, whatever its data inputs do.
- R10: The encoder and decoder accept words in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| encValid | input | 1 | Encoder input strobe |
| encData | input | 4 | Data to protect (d1 in bit 3) |
| encOutValid | output | 1 | Encoder result valid |
| encCode | output | 7 | Codeword (position 1 in bit 6) |
| decValid | input | 1 | Decoder input strobe |
| decCode | input | 7 | Received word (position 1 in bit 6) |
| decOutValid | output | 1 | Decoder result valid |
| decData | output | 4 | Corrected data (d1 in bit 3) |
| decSyndrome | output | 3 | Syndrome (row 1 in bit 2) |
| decError | output | 1 | High when the syndrome is nonzero |

## Verification
The encoder and the decoder can both take a word on the same clock edge. The bench provokes this by raising both strobes at one falling edge, with a data word on the encoder and a single-error word on the decoder. It then judges both registered results one cycle later against values it computes itself: the codeword, and the repaired data and syndrome. It also repeats the clock with only one strobe raised, to show that the idle path holds its outputs while the other changes.

// File: rtl/sec74_pkg.sv
package sec74_pkg;
  localparam int DATA_W = 4;
  localparam int PAR_W  = 3;
  localparam int CODE_W = DATA_W + PAR_W;

  // check rows, row 1 first; each row written position 1 (MSB) to position 7
  localparam logic [PAR_W*CODE_W-1:0] CHECK_ROWS = {7'b1000111, 7'b0101011, 7'b0011101};

  function automatic logic [CODE_W-1:0] checkRow(input int j);
    return CHECK_ROWS[(PAR_W-1-j)*CODE_W +: CODE_W];
  endfunction

  // column of the check matrix for vector bit b, row 1 in the MSB
  function automatic logic [PAR_W-1:0] checkCol(input int b);
    logic [PAR_W-1:0] col;
    logic [CODE_W-1:0] row;
    for (int j = 0; j < PAR_W; j++) begin
      row = checkRow(j);
      col[PAR_W-1-j] = row[b];
    end
    return col;
  endfunction

  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } strobe_t;
endpackage

// File: rtl/sec74_ctrl.sv
module sec74_ctrl
  import sec74_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    encValid,
  input  logic    decValid,
  output strobe_t strobes,
  output logic    encOutValid,
  output logic    decOutValid
);
  always_comb begin
    strobes.encLoad = encValid & ~rst;
    strobes.decLoad = decValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      encOutValid <= 1'b0;
      decOutValid <= 1'b0;
    end else begin
      encOutValid <= encValid;
      decOutValid <= decValid;
    end
  end
endmodule

// File: rtl/sec74_datapath.sv
module sec74_datapath
  import sec74_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] encData,
  input  logic [CODE_W-1:0] decCode,
  output logic [CODE_W-1:0] encCode,
  output logic [DATA_W-1:0] decData,
  output logic [PAR_W-1:0]  decSyndrome,
  output logic              decError
);
  logic [PAR_W-1:0]  encParity;
  logic [PAR_W-1:0]  syn;
  logic [CODE_W-1:0] flipMask;
  logic [CODE_W-1:0] fixedWord;

  // parity and syndrome, one XOR tree per check row
  for (genvar j = 0; j < PAR_W; j++) begin : g_row
    localparam logic [CODE_W-1:0] ROW = checkRow(j);
    assign encParity[PAR_W-1-j] = ^(encData & ROW[DATA_W-1:0]);
    assign syn[PAR_W-1-j]       = ^(decCode & ROW);
  end

  // one comparator per position; the columns are distinct and nonzero
  for (genvar b = 0; b < CODE_W; b++) begin : g_pos
    localparam logic [PAR_W-1:0] COL = checkCol(b);
    assign flipMask[b] = (syn == COL);
  end

  assign fixedWord = decCode ^ flipMask;

  always_ff @(posedge clk) begin
    if (rst) begin
      encCode     <= '0;
      decData     <= '0;
      decSyndrome <= '0;
      decError    <= 1'b0;
    end else begin
      if (strobes.encLoad) encCode <= {encParity, encData};
      if (strobes.decLoad) begin
        decData     <= fixedWord[DATA_W-1:0];
        decSyndrome <= syn;
        decError    <= |syn;
      end
    end
  end
endmodule

// File: rtl/sec74_codec.sv
module sec74_codec
  import sec74_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              encValid,
  input  logic [DATA_W-1:0] encData,
  output logic              encOutValid,
  output logic [CODE_W-1:0] encCode,
  input  logic              decValid,
  input  logic [CODE_W-1:0] decCode,
  output logic              decOutValid,
  output logic [DATA_W-1:0] decData,
  output logic [PAR_W-1:0]  decSyndrome,
  output logic              decError
);
  strobe_t strobes;

  sec74_ctrl ctrl_i (
    .clk(clk), .rst(rst), .encValid(encValid), .decValid(decValid),
    .strobes(strobes), .encOutValid(encOutValid), .decOutValid(decOutValid)
  );

  sec74_datapath dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .encData(encData), .decCode(decCode),
    .encCode(encCode), .decData(decData), .decSyndrome(decSyndrome), .decError(decError)
  );
endmodule

// File: rtl/sec74_checker.sv
module sec74_checker
  import sec74_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              encValid,
  input logic [DATA_W-1:0] encData,
  input logic              encOutValid,
  input logic [CODE_W-1:0] encCode,
  input logic              decValid,
  input logic [CODE_W-1:0] decCode,
  input logic              decOutValid,
  input logic [DATA_W-1:0] decData,
  input logic [PAR_W-1:0]  decSyndrome,
  input logic              decError
);
  localparam logic [CODE_W-1:0] ROW1 = checkRow(0);
  localparam logic [CODE_W-1:0] ROW2 = checkRow(1);
  localparam logic [CODE_W-1:0] ROW3 = checkRow(2);

  AST_ENC_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    encValid |=> encOutValid);  // R2
  AST_ENC_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !encValid |=> !encOutValid);  // R2
  AST_ENC_SYSTEMATIC: assert property (@(posedge clk) disable iff (rst)
    encValid |=> encCode[DATA_W-1:0] == $past(encData));  // R1
  AST_ENC_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
    encOutValid |-> ((^(encCode & ROW1)) == 1'b0 && (^(encCode & ROW2)) == 1'b0 && (^(encCode & ROW3)) == 1'b0));  // R1
  AST_DEC_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    decValid |=> decOutValid);  // R7
  AST_DEC_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    (decValid && (^(decCode & ROW1)) == 1'b0 && (^(decCode & ROW2)) == 1'b0 && (^(decCode & ROW3)) == 1'b0)
    |=> (decData == $past(decCode[DATA_W-1:0]) && !decError));  // R4
  AST_DEC_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    decOutValid |-> (decError == (decSyndrome != '0)));  // R5
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !decValid |=> $stable(decData) && $stable(decSyndrome));  // R9
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !encValid |=> $stable(encCode));  // R9
endmodule

bind sec74_codec sec74_checker chk_i (
  .clk(clk), .rst(rst), .encValid(encValid), .encData(encData), .encOutValid(encOutValid),
  .encCode(encCode), .decValid(decValid), .decCode(decCode), .decOutValid(decOutValid),
  .decData(decData), .decSyndrome(decSyndrome), .decError(decError)
);

// File: tb/sec74_codec_tb_top.sv
module sec74_codec_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       encValid = 1'b0;
  logic [3:0] encData = '0;
  logic       encOutValid;
  logic [6:0] encCode;
  logic       decValid = 1'b0;
  logic [6:0] decCode = '0;
  logic       decOutValid;
  logic [3:0] decData;
  logic [2:0] decSyndrome;
  logic       decError;

  int vecCount  = 0;
  int missCount = 0;

  always #4 clk = ~clk;

  sec74_codec dut_i (
    .clk(clk), .rst(rst), .encValid(encValid), .encData(encData), .encOutValid(encOutValid),
    .encCode(encCode), .decValid(decValid), .decCode(decCode), .decOutValid(decOutValid),
    .decData(decData), .decSyndrome(decSyndrome), .decError(decError)
  );

  function automatic logic [6:0] refEncode(input logic [3:0] d);
    logic p1, p2, p3;
    p1 = d[2] ^ d[1] ^ d[0];
    p2 = d[3] ^ d[1] ^ d[0];
    p3 = d[3] ^ d[2] ^ d[0];
    return {p1, p2, p3, d};
  endfunction

  function automatic logic [2:0] refColumn(input int pos);
    case (pos)
      1: return 3'b100;
      2: return 3'b010;
      3: return 3'b001;
      4: return 3'b011;
      5: return 3'b101;
      6: return 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runEncode(input logic [3:0] d, input string tag);
    @(negedge clk); encValid = 1'b1; encData = d;
    @(negedge clk); encValid = 1'b0;
    checkVal({tag, " R2 encOutValid"}, {31'b0, encOutValid}, 32'd1);
    checkVal({tag, " R1 encCode"}, {25'b0, encCode}, {25'b0, refEncode(d)});
  endtask

  task automatic runDecode(input logic [6:0] w, input logic [3:0] expData,
                           input logic [2:0] expSyn, input string tag);
    @(negedge clk); decValid = 1'b1; decCode = w;
    @(negedge clk); decValid = 1'b0;
    checkVal({tag, " R7 decOutValid"}, {31'b0, decOutValid}, 32'd1);
    checkVal({tag, " R6 decData"}, {28'b0, decData}, {28'b0, expData});
    checkVal({tag, " R3 decSyndrome"}, {29'b0, decSyndrome}, {29'b0, expSyn});
    checkVal({tag, " R4/R5 decError"}, {31'b0, decError}, {31'b0, (expSyn != 3'b000)});
  endtask

  task automatic testReset();
    @(negedge clk);
    checkVal("R8 encOutValid in reset", {31'b0, encOutValid}, 32'd0);
    checkVal("R8 decOutValid in reset", {31'b0, decOutValid}, 32'd0);
    checkVal("R8 encCode in reset", {25'b0, encCode}, 32'd0);
    checkVal("R8 dec outputs in reset", {24'b0, decData, decSyndrome, decError}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic testKnown();
    runEncode(4'b1010, "known 1010");
    checkVal("R1 literal codeword", {25'b0, encCode}, {25'b0, 7'b1011010});
    runDecode(7'b1011011, 4'b1010, 3'b111, "known 1011011");
  endtask

  task automatic testEncodeAll();
    for (int d = 0; d < 16; d++) runEncode(d[3:0], "encode sweep");
  endtask

  task automatic testDecodeClean();
    for (int d = 0; d < 16; d++) runDecode(refEncode(d[3:0]), d[3:0], 3'b000, "R4 clean");
  endtask

  task automatic testSingleErrors();
    for (int d = 0; d < 16; d++)
      for (int pos = 1; pos <= 7; pos++)
        runDecode(refEncode(d[3:0]) ^ (7'b1 << (7 - pos)), d[3:0], refColumn(pos), "R5 single flip");
  endtask

  task automatic testHold();
    runEncode(4'b0110, "hold setup");
    runDecode(refEncode(4'b1001) ^ 7'b0000100, 4'b1001, 3'b101, "hold setup");
    @(negedge clk); encData = 4'b1111; decCode = 7'b1111111;
    @(negedge clk);
    checkVal("R9 encOutValid idle", {31'b0, encOutValid}, 32'd0);
    checkVal("R9 decOutValid idle", {31'b0, decOutValid}, 32'd0);
    checkVal("R9 encCode held", {25'b0, encCode}, {25'b0, refEncode(4'b0110)});
    checkVal("R9 decData held", {28'b0, decData}, 32'd9);
    checkVal("R9 decSyndrome held", {29'b0, decSyndrome}, 32'd5);
  endtask

  task automatic testConcurrent();
    @(negedge clk);
    encValid = 1'b1; encData = 4'b0011;
    decValid = 1'b1; decCode = refEncode(4'b1100) ^ 7'b1000000;
    @(negedge clk);
    encValid = 1'b0; decValid = 1'b0;
    checkVal("R10 both valids", {30'b0, encOutValid, decOutValid}, 32'd3);
    checkVal("R10 encCode", {25'b0, encCode}, {25'b0, refEncode(4'b0011)});
    checkVal("R10 decData", {28'b0, decData}, 32'hC);
    checkVal("R10 decSyndrome", {29'b0, decSyndrome}, 32'd4);
    // only the decoder fires; the encoder must hold
    @(negedge clk); decValid = 1'b1; decCode = refEncode(4'b0101); encData = 4'b1110;
    @(negedge clk); decValid = 1'b0;
    checkVal("R10 encCode untouched", {25'b0, encCode}, {25'b0, refEncode(4'b0011)});
    checkVal("R10 decData alone", {28'b0, decData}, 32'h5);
  endtask

  task automatic testMidReset();
    runDecode(7'b1011011, 4'b1010, 3'b111, "pre-reset");
    @(negedge clk); encValid = 1'b1; encData = 4'b1111; rst = 1'b1;
    @(negedge clk); encValid = 1'b0;
    checkVal("R8 encOutValid mid reset", {31'b0, encOutValid}, 32'd0);
    checkVal("R8 encCode mid reset", {25'b0, encCode}, 32'd0);
    checkVal("R8 dec outputs mid reset", {23'b0, decOutValid, decData, decSyndrome, decError}, 32'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testKnown();
    testEncodeAll();
    testDecodeClean();
    testSingleErrors();
    testHold();
    testConcurrent();
    testMidReset();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    #(8 * 100000);
    missCount++;
    $display("FAIL watchdog all requirements actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule